// File: doc/BRIEF.md
# Debug Mode Entry and Return Controller

This block sits beside a processor core's exception logic. It moves the core into debug mode and brings it back out. A debug exception request carries a cause word, a flag telling whether the faulting instruction sits in a branch delay slot, the current program counter and the compressed-instruction mode bit.

On entry, the block does four things:
- It rewrites the debug control register.
- It saves the return address, with the mode bit folded into bit 0, in the debug return-address register.
- It redirects fetch to a fixed debug vector with the compressed mode cleared.
- It pulses a request to drop any pending interrupt flag.

A return strobe leaves debug mode. It clears the mode bits and redirects fetch to the saved address. The compressed mode is restored from bit 0 of that address, and bit 0 of the new PC is forced to zero.

The register state is visible on output ports, so the core's register file and a debugger can read it. An entry taken while debug mode is already set is handled like any other entry, and a status output reports it as nested.

Top module: `dbg_excctl`

## Requirements
- R1: After reset, every output reads zero, including the control register, the return-address register and the redirect PC.
- R2: An entry replaces every cause-type bit of the control register with the bit at the same position of the cause word, so earlier type bits never survive. The type positions are:
  - bits 0 to 5: single step, breakpoint, data-break load, data-break store, instruction break, debug interrupt;
  - bits 10 to 14: exception code;
  - bits 18 and 19: imprecise data-break load and imprecise data-break store.
- R3: Cause-word bits outside the type positions have no effect. Control register bits that are neither type, delay-slot nor mode bits always read zero.
- R4: An entry writes control register bit 31 with the delay-slot flag.
- R5: An entry sets control register bit 30 (debug mode) and bit 20 (exception inhibit).
- R6: An entry loads the return-address register with the PC OR'd with the compressed-mode bit.
- R7: In the cycle after an entry, the redirect strobe is high, the redirect PC is 0xBFC00480 and the mode output is 0. The redirect PC and the mode output hold their values until the next event.
- R8: The interrupt-clear output is high for exactly the one cycle following each entry, and only then.
- R9: In the cycle after an entry, the nested output equals the debug-mode bit as it stood before that entry. At all other times it is 0.
- R10: A return clears bits 30 and 20. It leaves the delay-slot bit, the type bits and the return-address register unchanged.
- R11: In the cycle after a return, the redirect strobe is high. The redirect PC is the return address with bit 0 cleared, and the mode output equals bit 0 of the return address.
- R12: When an entry and a return arrive in the same cycle, the entry is taken and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_req_i | input | 1 | Debug exception request |
| dbg_cause_i | input | XLEN | Cause-type word for the request |
| dslot_i | input | 1 | Faulting instruction is in a delay slot |
| pc_i | input | XLEN | PC of the faulting instruction |
| isa_i | input | 1 | Current compressed-instruction mode |
| deret_i | input | 1 | Return-from-debug strobe |
| redirect_o | output | 1 | Fetch redirect strobe |
| new_pc_o | output | XLEN | Redirect target PC |
| isa_o | output | 1 | Compressed mode after the redirect |
| irq_clr_o | output | 1 | Clear the pending interrupt flag |
| nested_o | output | 1 | Last entry happened inside debug mode |
| dbg_ctl_o | output | XLEN | Debug control register |
| depc_o | output | XLEN | Debug return-address register |

## Verification
The bench builds the block with its default parameters: a 32-bit word, the standard bit positions and the full type mask. This keeps the cause space small enough to cover completely. It sweeps every single-bit cause type against both delay-slot and both mode values, and all 32 exception-code values in a chain of entries that are nested inside debug mode. Expected register contents and redirect targets are computed arithmetically from the inputs. The same configuration makes the odd-PC return path, the all-ones and complement cause words, and the collision of an entry with a return reachable by direct stimulus.

// File: rtl/dbg_excctl_pkg.sv
package dbg_excctl_pkg;

   typedef enum logic [1:0] {
      EV_IDLE   = 2'd0,
      EV_ENTER  = 2'd1,
      EV_RETURN = 2'd2
   } dbg_ev_e;

   // default type-field mask: bits 0..5, 10..14, 18, 19
   localparam logic [31:0] DEF_TYPE_MASK = 32'h000C_7C3F;

endpackage

// File: rtl/dbg_ev_arb.sv
module dbg_ev_arb
   import dbg_excctl_pkg::*;
(
   input  logic    req_i,
   input  logic    ret_i,
   output dbg_ev_e ev_o
);
   // entry has priority over return
   always_comb begin
      if (req_i)      ev_o = EV_ENTER;
      else if (ret_i) ev_o = EV_RETURN;
      else            ev_o = EV_IDLE;
   end
endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
   import dbg_excctl_pkg::*;
#(
   parameter int          XLEN      = 32,
   parameter int          DM_POS    = 30,
   parameter int          DBD_POS   = 31,
   parameter int          IEXI_POS  = 20,
   parameter logic [31:0] TYPE_MASK = DEF_TYPE_MASK
) (
   input  logic            clk,
   input  logic            rst_n,
   input  dbg_ev_e         ev_i,
   input  logic [XLEN-1:0] cause_i,
   input  logic            dslot_i,
   output logic [XLEN-1:0] ctl_o,
   output logic            nested_o
);
   localparam logic [XLEN-1:0] MASK_W = XLEN'(TYPE_MASK);

   logic            enter, leave;
   logic [XLEN-1:0] ctl_d;
   logic            unused_cause;

   assign enter        = (ev_i == EV_ENTER);
   assign leave        = (ev_i == EV_RETURN);
   assign unused_cause = ^(cause_i & ~MASK_W);

   for (genvar i = 0; i < XLEN; i++) begin : g_bit
      if (MASK_W[i]) begin : g_type
         assign ctl_d[i] = enter ? cause_i[i] : ctl_o[i];
      end else if (i == DM_POS || i == IEXI_POS) begin : g_mode
         assign ctl_d[i] = enter ? 1'b1 : (leave ? 1'b0 : ctl_o[i]);
      end else if (i == DBD_POS) begin : g_slot
         assign ctl_d[i] = enter ? dslot_i : ctl_o[i];
      end else begin : g_zero
         assign ctl_d[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_o    <= '0;
         nested_o <= 1'b0;
      end else begin
         ctl_o    <= ctl_d;
         nested_o <= enter & ctl_o[DM_POS];
      end
   end
endmodule

// File: rtl/dbg_pc_path.sv
module dbg_pc_path
   import dbg_excctl_pkg::*;
#(
   parameter int              XLEN = 32,
   parameter logic [XLEN-1:0] VEC  = 32'hBFC0_0480
) (
   input  logic            clk,
   input  logic            rst_n,
   input  dbg_ev_e         ev_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic            isa_i,
   output logic [XLEN-1:0] depc_o,
   output logic [XLEN-1:0] new_pc_o,
   output logic            isa_o,
   output logic            redirect_o,
   output logic            irq_clr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depc_o     <= '0;
         new_pc_o   <= '0;
         isa_o      <= 1'b0;
         redirect_o <= 1'b0;
         irq_clr_o  <= 1'b0;
      end else begin
         redirect_o <= (ev_i != EV_IDLE);
         irq_clr_o  <= (ev_i == EV_ENTER);
         unique case (ev_i)
            EV_ENTER: begin
               depc_o   <= pc_i | XLEN'(isa_i);
               new_pc_o <= VEC;
               isa_o    <= 1'b0;
            end
            EV_RETURN: begin
               new_pc_o <= {depc_o[XLEN-1:1], 1'b0};
               isa_o    <= depc_o[0];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dbg_excctl.sv
module dbg_excctl
   import dbg_excctl_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter logic [XLEN-1:0] VEC       = 32'hBFC0_0480,
   parameter int              DM_POS    = 30,
   parameter int              DBD_POS   = 31,
   parameter int              IEXI_POS  = 20,
   parameter logic [31:0]     TYPE_MASK = DEF_TYPE_MASK
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dbg_req_i,
   input  logic [XLEN-1:0] dbg_cause_i,
   input  logic            dslot_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic            isa_i,
   input  logic            deret_i,
   output logic            redirect_o,
   output logic [XLEN-1:0] new_pc_o,
   output logic            isa_o,
   output logic            irq_clr_o,
   output logic            nested_o,
   output logic [XLEN-1:0] dbg_ctl_o,
   output logic [XLEN-1:0] depc_o
);
   localparam logic [XLEN-1:0] MASK_W = XLEN'(TYPE_MASK);

   if (XLEN < 32) begin : g_bad_xlen
      $error("dbg_excctl: XLEN must be at least 32");
   end
   if (DM_POS >= XLEN || DBD_POS >= XLEN || IEXI_POS >= XLEN) begin : g_bad_pos
      $error("dbg_excctl: control bit position outside the word");
   end
   if (DM_POS == DBD_POS || DM_POS == IEXI_POS || DBD_POS == IEXI_POS) begin : g_bad_dup
      $error("dbg_excctl: control bit positions overlap");
   end
   if (MASK_W[DM_POS] || MASK_W[DBD_POS] || MASK_W[IEXI_POS]) begin : g_bad_mask
      $error("dbg_excctl: type mask covers a control bit");
   end
   if (VEC[0]) begin : g_bad_vec
      $error("dbg_excctl: debug vector must be even");
   end

   dbg_ev_e ev;

   dbg_ev_arb u_arb (
      .req_i (dbg_req_i),
      .ret_i (deret_i),
      .ev_o  (ev)
   );

   dbg_ctl_reg #(
      .XLEN      (XLEN),
      .DM_POS    (DM_POS),
      .DBD_POS   (DBD_POS),
      .IEXI_POS  (IEXI_POS),
      .TYPE_MASK (TYPE_MASK)
   ) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_i     (ev),
      .cause_i  (dbg_cause_i),
      .dslot_i  (dslot_i),
      .ctl_o    (dbg_ctl_o),
      .nested_o (nested_o)
   );

   dbg_pc_path #(
      .XLEN (XLEN),
      .VEC  (VEC)
   ) u_pc (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_i       (ev),
      .pc_i       (pc_i),
      .isa_i      (isa_i),
      .depc_o     (depc_o),
      .new_pc_o   (new_pc_o),
      .isa_o      (isa_o),
      .redirect_o (redirect_o),
      .irq_clr_o  (irq_clr_o)
   );
endmodule

// File: rtl/dbg_excctl_chk.sv
module dbg_excctl_chk #(
   parameter int              XLEN      = 32,
   parameter logic [XLEN-1:0] VEC       = 32'hBFC0_0480,
   parameter int              DM_POS    = 30,
   parameter int              DBD_POS   = 31,
   parameter int              IEXI_POS  = 20,
   parameter logic [31:0]     TYPE_MASK = 32'h000C_7C3F
) (
   input logic            clk,
   input logic            rst_n,
   input logic            dbg_req_i,
   input logic [XLEN-1:0] dbg_cause_i,
   input logic            dslot_i,
   input logic [XLEN-1:0] pc_i,
   input logic            isa_i,
   input logic            deret_i,
   input logic            redirect_o,
   input logic [XLEN-1:0] new_pc_o,
   input logic            isa_o,
   input logic            irq_clr_o,
   input logic            nested_o,
   input logic [XLEN-1:0] dbg_ctl_o,
   input logic [XLEN-1:0] depc_o
);
   localparam logic [XLEN-1:0] MASK_W = XLEN'(TYPE_MASK);
   localparam logic [XLEN-1:0] LIVE_W = MASK_W | (XLEN'(1) << DM_POS)
                                      | (XLEN'(1) << DBD_POS) | (XLEN'(1) << IEXI_POS);

   // R2
   type_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req_i |=> (dbg_ctl_o & MASK_W) == ($past(dbg_cause_i) & MASK_W));
   // R3
   dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_ctl_o & ~LIVE_W) == '0);
   // R4
   dslot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req_i |=> dbg_ctl_o[DBD_POS] == $past(dslot_i));
   // R5
   mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req_i |=> dbg_ctl_o[DM_POS] && dbg_ctl_o[IEXI_POS]);
   // R6
   depc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req_i |=> depc_o == ($past(pc_i) | XLEN'($past(isa_i))));
   // R7
   vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req_i |=> redirect_o && new_pc_o == VEC && !isa_o);
   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_req_i && !deret_i |=> !redirect_o && $stable(new_pc_o) && $stable(isa_o));
   // R8
   irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req_i |=> irq_clr_o);
   // R8
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_req_i |=> !irq_clr_o);
   // R9
   nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req_i |=> nested_o == $past(dbg_ctl_o[DM_POS]));
   // R9
   nested_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_req_i |=> !nested_o);
   // R10
   ret_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deret_i && !dbg_req_i |=> !dbg_ctl_o[DM_POS] && !dbg_ctl_o[IEXI_POS]
         && $stable(depc_o) && dbg_ctl_o[DBD_POS] == $past(dbg_ctl_o[DBD_POS]));
   // R11
   ret_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deret_i && !dbg_req_i |=> redirect_o
         && new_pc_o == ($past(depc_o) & ~XLEN'(1)) && isa_o == $past(depc_o[0]));
   // R12
   collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req_i && deret_i |=> dbg_ctl_o[DM_POS] && new_pc_o == VEC);
endmodule

bind dbg_excctl dbg_excctl_chk #(
   .XLEN      (XLEN),
   .VEC       (VEC),
   .DM_POS    (DM_POS),
   .DBD_POS   (DBD_POS),
   .IEXI_POS  (IEXI_POS),
   .TYPE_MASK (TYPE_MASK)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dbg_req_i   (dbg_req_i),
   .dbg_cause_i (dbg_cause_i),
   .dslot_i     (dslot_i),
   .pc_i        (pc_i),
   .isa_i       (isa_i),
   .deret_i     (deret_i),
   .redirect_o  (redirect_o),
   .new_pc_o    (new_pc_o),
   .isa_o       (isa_o),
   .irq_clr_o   (irq_clr_o),
   .nested_o    (nested_o),
   .dbg_ctl_o   (dbg_ctl_o),
   .depc_o      (depc_o)
);

// File: tb/dbg_excctl_tb.sv
`timescale 1ns/1ps
module dbg_excctl_tb;
   localparam logic [31:0] TMASK = 32'h000C_7C3F;
   localparam logic [31:0] VECT  = 32'hBFC0_0480;
   localparam logic [31:0] DMB   = 32'h4000_0000;
   localparam logic [31:0] IXB   = 32'h0010_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, dslot = 1'b0, isa = 1'b0, deret = 1'b0;
   logic [31:0] cause = '0, pc = '0;
   logic        redirect, isa_out, irq_clr, nested;
   logic [31:0] new_pc, ctl, depc;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   dbg_excctl u_dut (
      .clk(clk), .rst_n(rst_n), .dbg_req_i(req), .dbg_cause_i(cause),
      .dslot_i(dslot), .pc_i(pc), .isa_i(isa), .deret_i(deret),
      .redirect_o(redirect), .new_pc_o(new_pc), .isa_o(isa_out),
      .irq_clr_o(irq_clr), .nested_o(nested), .dbg_ctl_o(ctl), .depc_o(depc)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_ctl(input logic [31:0] c, input logic s);
      return (c & TMASK) | (s ? 32'h8000_0000 : 32'h0) | DMB | IXB;
   endfunction

   task automatic enter(input logic [31:0] c, input logic s, input logic [31:0] p, input logic m,
                        input logic exp_nest);
      @(negedge clk);
      req = 1'b1; cause = c; dslot = s; pc = p; isa = m;
      @(negedge clk);
      req = 1'b0;
      chk(ctl == exp_ctl(c, s), "R2/R4/R5 ctl", ctl, exp_ctl(c, s));
      chk(depc == (p | {31'b0, m}), "R6 depc", depc, p | {31'b0, m});
      chk(redirect && new_pc == VECT && !isa_out, "R7 vector", new_pc, VECT);
      chk(irq_clr == 1'b1, "R8 irq_clr", {31'b0, irq_clr}, 32'h1);
      chk(nested == exp_nest, "R9 nested", {31'b0, nested}, {31'b0, exp_nest});
   endtask

   task automatic leave(input logic [31:0] ctl_before, input logic [31:0] dp);
      @(negedge clk);
      deret = 1'b1;
      @(negedge clk);
      deret = 1'b0;
      chk(ctl == (ctl_before & ~(DMB | IXB)), "R10 ctl", ctl, ctl_before & ~(DMB | IXB));
      chk(depc == dp, "R10 depc", depc, dp);
      chk(redirect && new_pc == (dp & ~32'h1), "R11 pc", new_pc, dp & ~32'h1);
      chk(isa_out == dp[0], "R11 isa", {31'b0, isa_out}, {31'b0, dp[0]});
      chk(!irq_clr && !nested, "R8 no clr on return", {30'b0, irq_clr, nested}, 32'h0);
      @(negedge clk);
      chk(!redirect && new_pc == (dp & ~32'h1), "R7 hold", new_pc, dp & ~32'h1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ctl == 0 && depc == 0, "R1 regs", ctl | depc, 32'h0);
      chk(new_pc == 0 && !redirect && !isa_out && !irq_clr && !nested, "R1 outs", new_pc, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ctl == 0 && !redirect, "R1 after release", ctl, 32'h0);

      // R2 R4 R5 R6 R7 R8 R9 R10 R11: single-bit cause sweep
      for (int k = 0; k < 32; k++) begin
         if (TMASK[k] && (k < 10 || k > 14)) begin
            for (int s = 0; s < 2; s++) begin
               for (int m = 0; m < 2; m++) begin
                  logic [31:0] p;
                  p = 32'h8000_0100 + (k << 4);
                  enter(32'h1 << k, s[0], p, m[0], 1'b0);
                  leave(exp_ctl(32'h1 << k, s[0]), p | {31'b0, m[0]});
               end
            end
         end
      end

      // R2 R9: exception-code sweep, nested after the first entry
      for (int e = 0; e < 32; e++) begin
         enter(32'(e) << 10, e[0], 32'h0000_2000 + (e << 2), 1'b0, e != 0);
      end
      leave(exp_ctl(32'(31) << 10, 1'b1), 32'h0000_2000 + (31 << 2));

      // R3: bits outside the type field are ignored
      enter(32'hFFFF_FFFF, 1'b0, 32'h0000_4000, 1'b0, 1'b0);
      chk(ctl == (TMASK | DMB | IXB), "R3 all ones", ctl, TMASK | DMB | IXB);
      enter(~TMASK, 1'b0, 32'h0000_4000, 1'b0, 1'b1);
      chk(ctl == (DMB | IXB), "R3 complement", ctl, DMB | IXB);
      leave(DMB | IXB, 32'h0000_4000);

      // R11: odd saved PC selects compressed mode on return
      enter(32'h1, 1'b0, 32'h0000_1001, 1'b0, 1'b0);
      leave(exp_ctl(32'h1, 1'b0), 32'h0000_1001);

      // R12: simultaneous entry and return
      @(negedge clk);
      req = 1'b1; deret = 1'b1; cause = 32'h2; dslot = 1'b1; pc = 32'h0000_3000; isa = 1'b1;
      @(negedge clk);
      req = 1'b0; deret = 1'b0;
      chk(ctl == exp_ctl(32'h2, 1'b1), "R12 ctl", ctl, exp_ctl(32'h2, 1'b1));
      chk(new_pc == VECT && !isa_out && irq_clr, "R12 vector", new_pc, VECT);
      chk(depc == 32'h0000_3001, "R12 depc", depc, 32'h0000_3001);
      @(negedge clk);
      chk(!irq_clr && !nested && !redirect, "R8 single pulse", {29'b0, irq_clr, nested, redirect}, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule